// File: doc/BRIEF.md
# Two-Stage Register Write Guard

This block decides whether each byte written to a bank of clock and control registers may land. An upstream serial-bus slave hands it decoded transactions: start, stop and abort strobes, a byte address and write data per byte, and a read strobe. The block passes each byte to a volatile clock group or a non-volatile control group only when a two-step unlock is in place and no non-volatile write cycle is still running.

The unlock lives in two latches held behind a single status byte. A general write-enable latch is set by one status code. A register write-enable latch is set by a second code, and only if the first latch is already set. Status bytes take effect when their transaction ends with a stop. A protected transaction that ends with a stop clears the register write-enable latch, so each change must be unlocked again. A transaction that is aborted or restarted keeps the latches as they were. A stop that ends an accepted non-volatile write starts a busy period, counted in clock cycles, during which protected bytes are refused.

Top module: `reg_write_guard`

## Requirements
- R1: After synchronous reset, gen_wr_en, reg_wr_en and busy are 0, and neither permit output is asserted.
- R2: A transaction holding exactly one byte to the status address 3Fh with value 02h, ended by a stop, sets gen_wr_en from the cycle after the stop and leaves reg_wr_en unchanged.
- R3: A lone status byte 06h ended by a stop sets both reg_wr_en and gen_wr_en when gen_wr_en was already 1. When gen_wr_en was 0, it has no effect.
- R4: A lone status byte 00h ended by a stop clears both latches.
- R5: A lone status byte of any value other than 00h, 02h or 06h leaves both latches unchanged.
- R6: Inside an open transaction, a byte to addresses 30h–37h raises vol_wr_ok in the same cycle, and a byte to 10h–14h raises nv_wr_ok in the same cycle. This happens only when both latches are 1 and busy is 0.
- R7: A byte to any other address outside 3Fh raises no permit and changes neither latch.
- R8: A stop that ends a transaction in which at least one protected byte was permitted clears reg_wr_en on the next cycle and leaves gen_wr_en set.
- R9: An abort, or a start arriving while a transaction is open, discards that transaction. A pending status byte is not applied, and reg_wr_en keeps its value.
- R10: Read strobes do not change either latch.
- R11: A stop ending a transaction with a permitted non-volatile byte drives busy high for exactly BUSY_CYCLES cycles, starting the cycle after the stop. A transaction with only volatile bytes leaves busy at 0.
- R12: While busy is 1, protected bytes are refused, and status bytes are still applied.
- R13: A status byte is ignored when its transaction also carries another byte, whether a second status byte or a byte to another address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| txn_start | input | 1 | Transaction start, or repeated start when one is open |
| txn_stop | input | 1 | Normal end of transaction |
| txn_abort | input | 1 | Abnormal end of transaction (bad bit count, framing error) |
| wr_valid | input | 1 | One write byte present this cycle |
| wr_addr | input | 8 | Register address of the byte |
| wr_data | input | 8 | Byte value |
| rd_strobe | input | 1 | A register byte is being read |
| vol_wr_ok | output | 1 | Byte may be written into the volatile clock group |
| nv_wr_ok | output | 1 | Byte may be written into the non-volatile control group |
| gen_wr_en | output | 1 | General write-enable latch |
| reg_wr_en | output | 1 | Register write-enable latch |
| busy | output | 1 | Non-volatile write cycle in progress |

## Verification
The bench tries the second unlock code before the first. A guard that ignores the order would open on a single byte. It checks that a protected stop re-locks the bank, and that an abort or a repeated start does not re-lock it. A design that tied the clear to every transaction end would fail that case. Status bytes are also sent with illegal values and in multi-byte transactions, where a loose decoder would change the latches. The busy window is counted cycle by cycle and protected bytes are tried inside it, which exposes an off-by-one counter or a guard that ignores busy.

// File: rtl/rwg_pkg.sv
package rwg_pkg;

    typedef enum logic [1:0] {
        REG_NONE,
        REG_CLOCK,
        REG_CTRL,
        REG_STAT
    } region_e;

    typedef enum logic [1:0] {
        SR_OP_KEEP,
        SR_OP_CLEAR,
        SR_OP_GEN,
        SR_OP_BOTH
    } sr_op_e;

    typedef struct packed {
        logic gen;
        logic reg_en;
    } latch_s;

    localparam logic [7:0] SR_CODE_CLEAR = 8'h00;
    localparam logic [7:0] SR_CODE_GEN   = 8'h02;
    localparam logic [7:0] SR_CODE_BOTH  = 8'h06;

    function automatic sr_op_e sr_decode(input logic [7:0] v);
        case (v)
            SR_CODE_CLEAR: return SR_OP_CLEAR;
            SR_CODE_GEN:   return SR_OP_GEN;
            SR_CODE_BOTH:  return SR_OP_BOTH;
            default:       return SR_OP_KEEP;
        endcase
    endfunction

    function automatic region_e region_of(input logic [7:0] addr,
                                          input int clk_base, input int clk_n,
                                          input int ctl_base, input int ctl_n,
                                          input int stat_addr);
        int a;
        a = int'(addr);
        if (a == stat_addr)                          return REG_STAT;
        if (a >= clk_base && a < clk_base + clk_n)   return REG_CLOCK;
        if (a >= ctl_base && a < ctl_base + ctl_n)   return REG_CTRL;
        return REG_NONE;
    endfunction

endpackage

// File: rtl/rwg_latch.sv
module rwg_latch
    import rwg_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   apply,
    input  sr_op_e op,
    input  logic   prot_done,
    output latch_s st
);

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else if (apply) begin
            case (op)
                SR_OP_CLEAR: st <= '0;
                SR_OP_GEN:   st.gen <= 1'b1;
                SR_OP_BOTH:  if (st.gen) st <= '{gen: 1'b1, reg_en: 1'b1};
                default:     st <= st;
            endcase
        end else if (prot_done) begin
            st.reg_en <= 1'b0;
        end
    end

    // R3
    reg_needs_gen_chk: assert property (@(posedge clk) disable iff (rst)
        st.reg_en |-> st.gen);

    // R3
    both_refused_chk: assert property (@(posedge clk) disable iff (rst)
        (apply && op == SR_OP_BOTH && !st.gen && !st.reg_en) |=> !st.reg_en);

    // R4
    clear_op_chk: assert property (@(posedge clk) disable iff (rst)
        (apply && op == SR_OP_CLEAR) |=> (!st.gen && !st.reg_en));

endmodule

// File: rtl/rwg_busy.sv
module rwg_busy #(
    parameter int unsigned CYCLES = 1000000
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy
);

    localparam int unsigned CW = $clog2(CYCLES + 1);
    localparam logic [CW-1:0] LOAD = CW'(CYCLES);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)             cnt <= '0;
        else if (start)      cnt <= LOAD;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign busy = (cnt != '0);

    // R11
    busy_load_chk: assert property (@(posedge clk) disable iff (rst)
        start |=> (cnt == LOAD));

    // R11
    busy_step_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !start) |=> (cnt == $past(cnt) - 1'b1));

endmodule

// File: rtl/reg_write_guard.sv
module reg_write_guard
    import rwg_pkg::*;
#(
    parameter int unsigned BUSY_CYCLES = 1000000,
    parameter int unsigned CLK_BASE    = 'h30,
    parameter int unsigned CLK_BYTES   = 8,
    parameter int unsigned CTL_BASE    = 'h10,
    parameter int unsigned CTL_BYTES   = 5,
    parameter int unsigned STAT_ADDR   = 'h3F
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       txn_start,
    input  logic       txn_stop,
    input  logic       txn_abort,
    input  logic       wr_valid,
    input  logic [7:0] wr_addr,
    input  logic [7:0] wr_data,
    input  logic       rd_strobe,
    output logic       vol_wr_ok,
    output logic       nv_wr_ok,
    output logic       gen_wr_en,
    output logic       reg_wr_en,
    output logic       busy
);

    region_e    region;
    latch_s     lat;
    logic       active;
    logic [1:0] stat_cnt;
    logic [7:0] stat_val;
    logic       other_seen;
    logic       vol_hit;
    logic       nv_hit;
    logic       byte_in;
    logic       guard_open;
    logic       end_ok;
    logic       apply;
    logic       prot_done;

    assign region = region_of(wr_addr, int'(CLK_BASE), int'(CLK_BYTES),
                              int'(CTL_BASE), int'(CTL_BYTES), int'(STAT_ADDR));

    assign byte_in    = wr_valid && active;
    assign guard_open = lat.gen && lat.reg_en && !busy;
    assign vol_wr_ok  = byte_in && (region == REG_CLOCK) && guard_open;
    assign nv_wr_ok   = byte_in && (region == REG_CTRL) && guard_open;

    assign end_ok    = txn_stop && active && !txn_abort && !txn_start;
    assign apply     = end_ok && (stat_cnt == 2'd1) && !other_seen;
    assign prot_done = end_ok && (vol_hit || nv_hit);

    always_ff @(posedge clk) begin
        if (rst) begin
            active     <= 1'b0;
            stat_cnt   <= '0;
            stat_val   <= '0;
            other_seen <= 1'b0;
            vol_hit    <= 1'b0;
            nv_hit     <= 1'b0;
        end else if (txn_start) begin
            active     <= 1'b1;
            stat_cnt   <= '0;
            other_seen <= 1'b0;
            vol_hit    <= 1'b0;
            nv_hit     <= 1'b0;
        end else if (txn_abort || txn_stop) begin
            active <= 1'b0;
        end else if (byte_in) begin
            if (region == REG_STAT) begin
                if (stat_cnt != 2'd2) stat_cnt <= stat_cnt + 1'b1;
                stat_val <= wr_data;
            end else begin
                other_seen <= 1'b1;
            end
            vol_hit <= vol_hit || vol_wr_ok;
            nv_hit  <= nv_hit || nv_wr_ok;
        end
    end

    rwg_latch u_latch (
        .clk       (clk),
        .rst       (rst),
        .apply     (apply),
        .op        (sr_decode(stat_val)),
        .prot_done (prot_done),
        .st        (lat)
    );

    rwg_busy #(.CYCLES(BUSY_CYCLES)) u_busy (
        .clk   (clk),
        .rst   (rst),
        .start (end_ok && nv_hit),
        .busy  (busy)
    );

    assign gen_wr_en = lat.gen;
    assign reg_wr_en = lat.reg_en;

    // R8
    relock_chk: assert property (@(posedge clk) disable iff (rst)
        (end_ok && (vol_hit || nv_hit)) |=> (!reg_wr_en && gen_wr_en));

    // R9
    abort_keeps_chk: assert property (@(posedge clk) disable iff (rst)
        (txn_abort || (txn_start && active)) |=> $stable(reg_wr_en));

    // R10
    read_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_strobe && !end_ok) |=> ($stable(gen_wr_en) && $stable(reg_wr_en)));

    // R11
    busy_begin_chk: assert property (@(posedge clk) disable iff (rst)
        (end_ok && nv_hit) |=> busy);

    // R6
    permit_locked_chk: assert property (@(posedge clk) disable iff (rst)
        (vol_wr_ok || nv_wr_ok) |-> (reg_wr_en && !busy));

endmodule

// File: tb/reg_write_guard_tb.sv
module reg_write_guard_tb_top;

    localparam int unsigned BUSY = 40;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       txn_start = 1'b0;
    logic       txn_stop = 1'b0;
    logic       txn_abort = 1'b0;
    logic       wr_valid = 1'b0;
    logic [7:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       rd_strobe = 1'b0;
    logic       vol_wr_ok, nv_wr_ok, gen_wr_en, reg_wr_en, busy;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    reg_write_guard #(.BUSY_CYCLES(BUSY)) dut_i (
        .clk(clk), .rst(rst), .txn_start(txn_start), .txn_stop(txn_stop),
        .txn_abort(txn_abort), .wr_valid(wr_valid), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_strobe(rd_strobe), .vol_wr_ok(vol_wr_ok),
        .nv_wr_ok(nv_wr_ok), .gen_wr_en(gen_wr_en), .reg_wr_en(reg_wr_en),
        .busy(busy)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic chk_lat(input logic g, input logic r, input string tag);
        check(gen_wr_en == g, {tag, " gen"}, int'(gen_wr_en), int'(g));
        check(reg_wr_en == r, {tag, " reg"}, int'(reg_wr_en), int'(r));
    endtask

    task automatic bstart();
        txn_start = 1'b1; @(negedge clk); txn_start = 1'b0;
    endtask
    task automatic bstop();
        txn_stop = 1'b1; @(negedge clk); txn_stop = 1'b0;
    endtask
    task automatic babort();
        txn_abort = 1'b1; @(negedge clk); txn_abort = 1'b0;
    endtask
    task automatic wbyte(input logic [7:0] a, input logic [7:0] d,
                         input logic ev, input logic en, input string tag);
        wr_valid = 1'b1; wr_addr = a; wr_data = d;
        #1;
        check(vol_wr_ok == ev, {tag, " vol permit"}, int'(vol_wr_ok), int'(ev));
        check(nv_wr_ok == en, {tag, " nv permit"}, int'(nv_wr_ok), int'(en));
        @(negedge clk); wr_valid = 1'b0;
    endtask
    task automatic sr_write(input logic [7:0] v, input string tag);
        bstart(); wbyte(8'h3F, v, 1'b0, 1'b0, tag); bstop();
    endtask

    task automatic t_reset();
        check(!gen_wr_en && !reg_wr_en && !busy, "R1 reset latches/busy",
              int'({gen_wr_en, reg_wr_en, busy}), 0);
        check(!vol_wr_ok && !nv_wr_ok, "R1 reset permits", int'({vol_wr_ok, nv_wr_ok}), 0);
    endtask

    task automatic t_unlock_order();
        sr_write(8'h06, "R3 06h before 02h");
        chk_lat(1'b0, 1'b0, "R3 out of order");
        sr_write(8'h02, "R2 write 02h");
        chk_lat(1'b1, 1'b0, "R2 gen set");
        bstart();
        wbyte(8'h30, 8'hAA, 1'b0, 1'b0, "R6 half unlocked clock");
        wbyte(8'h10, 8'hAA, 1'b0, 1'b0, "R6 half unlocked ctrl");
        bstop();
        chk_lat(1'b1, 1'b0, "R6 no change");
        sr_write(8'h06, "R3 write 06h");
        chk_lat(1'b1, 1'b1, "R3 both set");
    endtask

    task automatic t_read_undef();
        bstart();
        for (int i = 0; i < 4; i++) begin
            rd_strobe = 1'b1; @(negedge clk);
        end
        rd_strobe = 1'b0;
        bstop();
        chk_lat(1'b1, 1'b1, "R10 reads");
        bstart();
        wbyte(8'h20, 8'h11, 1'b0, 1'b0, "R7 addr 20h");
        wbyte(8'h38, 8'h11, 1'b0, 1'b0, "R7 addr 38h");
        wbyte(8'h15, 8'h11, 1'b0, 1'b0, "R7 addr 15h");
        bstop();
        chk_lat(1'b1, 1'b1, "R7 undefined");
    endtask

    task automatic t_clock_write();
        bstart();
        for (int i = 0; i < 8; i++)
            wbyte(8'h30 + 8'(i), 8'(i), 1'b1, 1'b0, "R6 clock byte");
        bstop();
        chk_lat(1'b1, 1'b0, "R8 relock");
        check(!busy, "R11 volatile no busy", int'(busy), 0);
    endtask

    task automatic t_bad_status();
        sr_write(8'h06, "R3 relock 06h");
        chk_lat(1'b1, 1'b1, "R3 reunlock");
        sr_write(8'h55, "R5 value 55h");
        chk_lat(1'b1, 1'b1, "R5 ignored");
        sr_write(8'h04, "R5 value 04h");
        chk_lat(1'b1, 1'b1, "R5 ignored 04h");
        bstart();
        wbyte(8'h3F, 8'h00, 1'b0, 1'b0, "R13 first");
        wbyte(8'h3F, 8'h00, 1'b0, 1'b0, "R13 second");
        bstop();
        chk_lat(1'b1, 1'b1, "R13 two status bytes");
        bstart();
        wbyte(8'h3F, 8'h00, 1'b0, 1'b0, "R13 status");
        wbyte(8'h20, 8'h00, 1'b0, 1'b0, "R13 other");
        bstop();
        chk_lat(1'b1, 1'b1, "R13 mixed");
    endtask

    task automatic t_abort_and_busy();
        int n;
        bstart();
        wbyte(8'h10, 8'h01, 1'b0, 1'b1, "R6 ctrl before abort");
        babort();
        chk_lat(1'b1, 1'b1, "R9 abort keeps");
        check(!busy, "R9 abort no busy", int'(busy), 0);
        bstart();
        for (int i = 0; i < 5; i++)
            wbyte(8'h10 + 8'(i), 8'(i), 1'b0, 1'b1, "R6 ctrl byte");
        bstop();
        chk_lat(1'b1, 1'b0, "R8 ctrl relock");
        n = 0;
        while (busy && n < 1000) begin
            n++; @(negedge clk);
        end
        check(n == int'(BUSY), "R11 busy length", n, int'(BUSY));
    endtask

    task automatic t_busy_block();
        sr_write(8'h06, "R12 unlock");
        bstart(); wbyte(8'h10, 8'h00, 1'b0, 1'b1, "R12 ctrl"); bstop();
        check(busy == 1'b1, "R12 busy started", int'(busy), 1);
        sr_write(8'h06, "R12 status in busy");
        chk_lat(1'b1, 1'b1, "R12 status applied");
        bstart();
        wbyte(8'h30, 8'h00, 1'b0, 1'b0, "R12 clock refused");
        wbyte(8'h11, 8'h00, 1'b0, 1'b0, "R12 ctrl refused");
        bstop();
        chk_lat(1'b1, 1'b1, "R12 no relock");
        while (busy) @(negedge clk);
        bstart(); wbyte(8'h31, 8'h00, 1'b1, 1'b0, "R12 after busy"); bstop();
        chk_lat(1'b1, 1'b0, "R8 after busy");
    endtask

    task automatic t_clear_restart();
        sr_write(8'h06, "R4 prep");
        sr_write(8'h00, "R4 clear");
        chk_lat(1'b0, 1'b0, "R4 both cleared");
        bstart();
        wbyte(8'h3F, 8'h02, 1'b0, 1'b0, "R9 pending");
        bstart();
        bstop();
        chk_lat(1'b0, 1'b0, "R9 restart discards");
        bstart();
        wbyte(8'h3F, 8'h02, 1'b0, 1'b0, "R9 pending abort");
        babort();
        chk_lat(1'b0, 1'b0, "R9 abort discards");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_unlock_order();
        t_read_undef();
        t_clock_write();
        t_bad_status();
        t_abort_and_busy();
        t_busy_block();
        t_clear_restart();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule